// File: doc/BRIEF.md
# Buffered Multi-Word Program Command Decoder

This block is the command front end of one bank of a parallel NOR flash. It watches bus write cycles (address, 16-bit data, write strobe) and walks them through a fixed sequence. A setup write opens the sequence. A count write names how many words follow. The load writes each carry one address and one data word into an internal write buffer. A confirm write starts a programming pass. The pass is modelled behaviourally: each buffered word is ANDed into a small array model, and the bank then stays busy for a parameterised number of cycles.

The block keeps a status register. Reads return that register from the setup write on, or after a read-status command, and return the array model after a read-array command. The controller checks the sequence, the block and address-range rules and the per-block protection input. Any violation aborts the operation with the array untouched. A setup that arrives while sequence-error bits are still set is refused. During the busy phase only the two read-mode commands have an effect.

FSM states: `S_IDLE` (command decode), `S_COUNT` (expects the word count), `S_LOAD` (takes n+1 address/data pairs), `S_CONFIRM` (expects the confirm code) and `S_BUSY` (programming and timer). Transitions:
- IDLE→COUNT on an accepted setup.
- COUNT→LOAD on a valid count.
- LOAD→CONFIRM after the last load.
- CONFIRM→BUSY on a valid confirm to an unprotected block.
- BUSY→IDLE when the timer expires.
- Every error sends COUNT, LOAD or CONFIRM back to IDLE, and so does a valid confirm to a protected block.

Top module: `flash_bufprog`

## Requirements
- R1: After reset, reads return the array model, every array word reads 0xFFFF, and the status register reads 0x0080. Status layout: bit 7 ready (1 = buffer available), bit 5 sequence error, bit 4 program error, bit 1 protection error, all other bits 0, upper byte 0.
- R2: Command codes sit in wdata[7:0]. 0xE8 is setup, 0x70 selects status reads and 0xFF selects array reads. After any setup write, reads return the status register.
- R3: The count write must lie in the same block as the setup write (block = addr[17:16]) and carry n ≤ 31. A violation sets bits 5 and 4 (status 0x00B0) and returns to idle.
- R4: Exactly n+1 load writes are taken, then a write of 0xD0 to the same block starts programming and leaves the status at 0x0080. Any other confirm write is a sequence error (0x00B0).
- R5: The first load sets the start address. Every load must be in the setup block and lie between start and start+n inclusive. A violation gives 0x00B0 and leaves the array unchanged.
- R6: Programming ANDs each loaded word into the array model, in load order, so bits only fall. The model keeps 32 words per block at index {addr[17:16], addr[4:0]}, so addresses that differ only in addr[15:5] alias.
- R7: Status bit 7 reads 0 for exactly BUSY_CYC cycles, starting the cycle after the confirm write, then returns to 1.
- R8: A valid confirm to a block whose prot bit is 1 sets bits 4 and 1 (status 0x0092). No busy phase follows and the array is unchanged.
- R9: A setup write while bits 5 and 4 are both set is refused. The block stays idle and later writes are decoded as commands. A write of 0x50 in idle clears bits 5, 4 and 1.
- R10: During the busy phase 0xFF and 0x70 still switch the read mode. All other writes, including 0x50 and 0xE8, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | 18 | Word address; bits 17:16 select the block |
| wdata | input | 16 | Write data: command code, count or program data |
| prot | input | 4 | Per-block protection, 1 = protected |
| rdata | output | 16 | Read data: status register or array word for addr |

## Verification
The hardest case to reach from the ports is a write that lands inside the busy window while earlier error bits are still set. It takes a protected-block abort that leaves bits 4 and 1 set, then a fresh accepted sequence, and then clear, read-array and setup writes while bit 7 is still low. The bench sets this up on purpose. It then checks that the array is readable mid-busy, that the refused setup did not switch reads back to status, and that the error bits outlived the clear. Random sequences add error injections at random load positions over the full range of counts. A bench model of the aliased array checks every word after each phase.

// File: rtl/flash_bp_pkg.sv
package flash_bp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COUNT,
        S_LOAD,
        S_CONFIRM,
        S_BUSY
    } bp_state_t;

    localparam logic [7:0] OP_SETUP       = 8'hE8;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_CLEAR       = 8'h50;
    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_READ_STATUS = 8'h70;

endpackage

// File: rtl/flash_bp_buffer.sv
module flash_bp_buffer #(
    parameter int DEPTH  = 32,
    parameter int OFS_W  = 5,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [OFS_W-1:0]  wofs,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [OFS_W-1:0]  rofs,
    output logic [DATA_W-1:0] rdata
);

    logic [OFS_W-1:0]  ofs_mem [DEPTH];
    logic [DATA_W-1:0] dat_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            ofs_mem[widx] <= wofs;
            dat_mem[widx] <= wdata;
        end
    end

    assign rofs  = ofs_mem[ridx];
    assign rdata = dat_mem[ridx];

endmodule

// File: rtl/flash_bp_array.sv
module flash_bp_array #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (prog_en) begin
            mem_q[prog_idx] <= mem_q[prog_idx] & prog_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/flash_bp_ctrl.sv
module flash_bp_ctrl
    import flash_bp_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int BLK_OFS_W = 16,
    parameter int BUF_WORDS = 32,
    parameter int BUSY_CYC  = 40,
    localparam int BLK_W    = ADDR_W - BLK_OFS_W,
    localparam int NUM_BLK  = 1 << BLK_W,
    localparam int CNT_W    = $clog2(BUF_WORDS),
    localparam int TMR_W    = $clog2(BUSY_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [15:0]        wdata,
    input  logic [NUM_BLK-1:0] prot,
    output logic               status_mode,
    output logic [7:0]         status,
    output logic               buf_we,
    output logic [CNT_W-1:0]   buf_widx,
    output logic               prog_en,
    output logic [CNT_W-1:0]   prog_idx,
    output logic [BLK_W-1:0]   cur_blk
);

    bp_state_t              state_q, nxt;
    logic [BLK_W-1:0]       blk_q;
    logic [CNT_W-1:0]       n_q, cnt_q;
    logic [BLK_OFS_W-1:0]   start_q;
    logic [TMR_W-1:0]       timer_q;
    logic [CNT_W:0]         pcnt_q;
    logic                   err_seq_q, err_prog_q, err_prot_q, mode_q;

    logic [BLK_W-1:0]       wblk;
    logic [BLK_OFS_W-1:0]   wofs, span;
    logic [7:0]             op;
    logic                   same_blk, in_range, seq_err, prot_err, start_busy;

    assign wblk     = addr[ADDR_W-1:BLK_OFS_W];
    assign wofs     = addr[BLK_OFS_W-1:0];
    assign op       = wdata[7:0];
    assign same_blk = (wblk == blk_q);
    assign span     = wofs - start_q;
    assign in_range = (cnt_q == '0) ||
                      ((wofs >= start_q) && (span <= BLK_OFS_W'(n_q)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= nxt;
    end

    // next-state decode and error classification
    always_comb begin
        nxt        = state_q;
        seq_err    = 1'b0;
        prot_err   = 1'b0;
        start_busy = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (wr_en && op == OP_SETUP && !(err_seq_q && err_prog_q))
                    nxt = S_COUNT;
            end
            S_COUNT: begin
                if (wr_en) begin
                    if (!same_blk || wdata > 16'(BUF_WORDS - 1)) begin
                        seq_err = 1'b1;
                        nxt     = S_IDLE;
                    end else begin
                        nxt = S_LOAD;
                    end
                end
            end
            S_LOAD: begin
                if (wr_en) begin
                    if (!same_blk || !in_range) begin
                        seq_err = 1'b1;
                        nxt     = S_IDLE;
                    end else if (cnt_q == n_q) begin
                        nxt = S_CONFIRM;
                    end
                end
            end
            S_CONFIRM: begin
                if (wr_en) begin
                    if (!same_blk || op != OP_CONFIRM) begin
                        seq_err = 1'b1;
                        nxt     = S_IDLE;
                    end else if (prot[blk_q]) begin
                        prot_err = 1'b1;
                        nxt      = S_IDLE;
                    end else begin
                        start_busy = 1'b1;
                        nxt        = S_BUSY;
                    end
                end
            end
            S_BUSY: begin
                if (timer_q == '0) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // sequence datapath and status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q      <= '0;
            n_q        <= '0;
            cnt_q      <= '0;
            start_q    <= '0;
            timer_q    <= '0;
            pcnt_q     <= '0;
            err_seq_q  <= 1'b0;
            err_prog_q <= 1'b0;
            err_prot_q <= 1'b0;
            mode_q     <= 1'b0;
        end else begin
            if (state_q == S_IDLE && wr_en) begin
                if (op == OP_SETUP) begin
                    mode_q <= 1'b1;
                    blk_q  <= wblk;
                end else if (op == OP_CLEAR) begin
                    err_seq_q  <= 1'b0;
                    err_prog_q <= 1'b0;
                    err_prot_q <= 1'b0;
                end else if (op == OP_READ_ARRAY) begin
                    mode_q <= 1'b0;
                end else if (op == OP_READ_STATUS) begin
                    mode_q <= 1'b1;
                end
            end
            if (state_q == S_COUNT && nxt == S_LOAD) begin
                n_q   <= wdata[CNT_W-1:0];
                cnt_q <= '0;
            end
            if (state_q == S_LOAD && wr_en && nxt != S_IDLE) begin
                if (cnt_q == '0) start_q <= wofs;
                cnt_q <= cnt_q + 1'b1;
            end
            if (start_busy) begin
                timer_q <= TMR_W'(BUSY_CYC - 1);
                pcnt_q  <= '0;
            end
            if (state_q == S_BUSY) begin
                if (timer_q != '0) timer_q <= timer_q - 1'b1;
                if (prog_en)       pcnt_q  <= pcnt_q + 1'b1;
                if (wr_en && op == OP_READ_ARRAY)  mode_q <= 1'b0;
                if (wr_en && op == OP_READ_STATUS) mode_q <= 1'b1;
            end
            if (seq_err) begin
                err_seq_q  <= 1'b1;
                err_prog_q <= 1'b1;
            end
            if (prot_err) begin
                err_prog_q <= 1'b1;
                err_prot_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        status_mode = mode_q;
        status      = {state_q != S_BUSY, 1'b0, err_seq_q, err_prog_q,
                       2'b00, err_prot_q, 1'b0};
        buf_we      = (state_q == S_LOAD) && wr_en && (nxt != S_IDLE);
        buf_widx    = cnt_q;
        prog_en     = (state_q == S_BUSY) && (pcnt_q <= {1'b0, n_q});
        prog_idx    = pcnt_q[CNT_W-1:0];
        cur_blk     = blk_q;
    end

    initial begin
        if (BUSY_CYC < BUF_WORDS)
            $error("BUSY_CYC must cover one cycle per buffered word");
    end

    // R3
    count_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COUNT && wr_en && wdata > 16'(BUF_WORDS - 1))
        |=> (state_q == S_IDLE && err_seq_q && err_prog_q));

    // R4
    load_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD) |-> (cnt_q <= n_q));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY && timer_q != '0) |=> (state_q == S_BUSY));

    // R9
    setup_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && wr_en && op == OP_SETUP && err_seq_q && err_prog_q)
        |=> (state_q == S_IDLE));

    // R10
    busy_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY && wr_en)
        |=> ($stable(err_seq_q) && $stable(err_prog_q) && $stable(err_prot_q)));

endmodule

// File: rtl/flash_bufprog.sv
module flash_bufprog #(
    parameter int ADDR_W    = 18,
    parameter int BLK_OFS_W = 16,
    parameter int BUF_WORDS = 32,
    parameter int WIN_W     = 5,
    parameter int BUSY_CYC  = 40,
    localparam int BLK_W    = ADDR_W - BLK_OFS_W,
    localparam int NUM_BLK  = 1 << BLK_W,
    localparam int CNT_W    = $clog2(BUF_WORDS),
    localparam int IDX_W    = BLK_W + WIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [15:0]        wdata,
    input  logic [NUM_BLK-1:0] prot,
    output logic [15:0]        rdata
);

    logic             status_mode, buf_we, prog_en;
    logic [7:0]       status;
    logic [CNT_W-1:0] buf_widx, prog_idx;
    logic [BLK_W-1:0] cur_blk;
    logic [WIN_W-1:0] buf_rofs;
    logic [15:0]      buf_rdata, arr_rdata;

    flash_bp_ctrl #(
        .ADDR_W(ADDR_W), .BLK_OFS_W(BLK_OFS_W),
        .BUF_WORDS(BUF_WORDS), .BUSY_CYC(BUSY_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .prot(prot), .status_mode(status_mode), .status(status),
        .buf_we(buf_we), .buf_widx(buf_widx), .prog_en(prog_en),
        .prog_idx(prog_idx), .cur_blk(cur_blk)
    );

    flash_bp_buffer #(
        .DEPTH(BUF_WORDS), .OFS_W(WIN_W), .DATA_W(16)
    ) u_buf (
        .clk(clk), .we(buf_we), .widx(buf_widx), .wofs(addr[WIN_W-1:0]),
        .wdata(wdata), .ridx(prog_idx), .rofs(buf_rofs), .rdata(buf_rdata)
    );

    flash_bp_array #(
        .IDX_W(IDX_W), .DATA_W(16)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
        .prog_idx({cur_blk, buf_rofs}), .prog_data(buf_rdata),
        .rd_idx({addr[ADDR_W-1:BLK_OFS_W], addr[WIN_W-1:0]}),
        .rd_data(arr_rdata)
    );

    assign rdata = status_mode ? {8'h00, status} : arr_rdata;

    // R8
    prot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> !prot[cur_blk]);

endmodule

// File: tb/tb_flash_bufprog.sv
module tb_flash_bufprog;

    localparam int BUSY_CYC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [3:0]  prot = '0;
    logic [15:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] model [128];
    logic [15:0] la [32];
    logic [15:0] ld [32];

    flash_bufprog #(.BUSY_CYC(BUSY_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .prot(prot), .rdata(rdata)
    );

    always #2 clk = ~clk;

    function automatic int aidx(input logic [17:0] a);
        return int'({a[17:16], a[4:0]});
    endfunction

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [17:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_ready(output int c);
        logic [15:0] d;
        c = 0;
        forever begin
            rd(18'h0, d);
            if (d[7] || c > 1000) break;
            c++;
        end
    endtask

    task automatic readback(input string tag);
        logic [15:0] d;
        wr(18'h0, 16'h00FF);
        for (int i = 0; i < 128; i++) begin
            logic [6:0] iv;
            iv = 7'(i);
            rd({iv[6:5], 11'b0, iv[4:0]}, d);
            chk(d, model[i], tag);
        end
    endtask

    // kind: 0 good, 1 count>31, 2 count other block, 3 load above range,
    //       4 load below start, 5 load other block, 6 bad confirm
    task automatic run_seq(input logic [1:0] blk, input int n_in, input int kind,
                           input bit apply);
        int n, ep;
        logic [15:0] s;
        logic [17:0] base, a;
        n = n_in;
        if (kind >= 3 && kind <= 5 && n == 0) n = 1;
        s = 16'(1 + $urandom % 63);
        base = {blk, 16'h0};
        la[0] = s;
        ld[0] = 16'($urandom | $urandom);
        for (int k = 1; k <= n; k++) begin
            la[k] = s + 16'($urandom % (n + 1));
            ld[k] = 16'($urandom | $urandom);
        end
        ep = (n > 0) ? 1 + int'($urandom % n) : 0;
        wr(base | 18'($urandom % 65536), 16'h00E8);
        if (kind == 1) begin wr(base, 16'(32 + $urandom % 200)); return; end
        if (kind == 2) begin wr({blk + 2'd1, 16'h0}, 16'(n)); return; end
        wr(base | 18'($urandom % 65536), 16'(n));
        for (int k = 0; k <= n; k++) begin
            a = {blk, la[k]};
            if (k == ep && kind == 3) a = {blk, s + 16'(n + 1 + $urandom % 4)};
            if (k == ep && kind == 4) a = {blk, s - 16'd1};
            if (k == ep && kind == 5) a = {blk + 2'd1, la[k]};
            wr(a, ld[k]);
            if (k == ep && kind >= 3 && kind <= 5) return;
        end
        if (kind == 6) begin wr(base, 16'h00D1); return; end
        wr(base | 18'($urandom % 65536), 16'h00D0);
        if (apply) begin
            for (int k = 0; k <= n; k++)
                model[aidx({blk, la[k]})] &= ld[k];
        end
    endtask

    task automatic do_case(input logic [1:0] blk, input int n, input int kind);
        logic [15:0] d;
        int c;
        string tag;
        run_seq(blk, n, kind, kind == 0);
        if (kind == 0) begin
            wait_ready(c);
            chk(16'(c), 16'(BUSY_CYC), "R7 busy length");
            rd(18'h0, d);
            chk(d, 16'h0080, "R4 status after program");
        end else begin
            tag = (kind <= 2) ? "R3 count error" :
                  (kind <= 5) ? "R5 load address error" : "R4 confirm error";
            rd(18'h0, d);
            chk(d, 16'h00B0, tag);
            wr(18'h0, 16'h0050);
            rd(18'h0, d);
            chk(d, 16'h0080, "R9 clear after error");
        end
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        int c;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(18'h0, d);
        chk(d, 16'hFFFF, "R1 array after reset");
        wr(18'h0, 16'h0070);
        rd(18'h0, d);
        chk(d, 16'h0080, "R1 status after reset");
        readback("R1 full array after reset");

        // R2 setup switches reads to status
        run_seq(2'd1, 3, 0, 1'b1);
        wait_ready(c);
        chk(16'(c), 16'(BUSY_CYC), "R7 busy length directed");
        rd(18'h1_0003, d);
        chk(d, 16'h0080, "R2 status after setup");
        readback("R6 directed program");

        // R6 second pass on the same words ANDs further
        run_seq(2'd1, 31, 0, 1'b1);
        wait_ready(c);
        readback("R6 and-accumulate");

        // R3, R5, R4 directed errors, array untouched
        do_case(2'd0, 5, 1);
        do_case(2'd0, 5, 2);
        do_case(2'd2, 4, 3);
        do_case(2'd2, 4, 4);
        do_case(2'd3, 6, 5);
        do_case(2'd3, 0, 6);
        readback("R5 array unchanged after aborts");

        // R9 refused setup while bits 5 and 4 set
        do_case(2'd0, 40, 1);
        run_seq(2'd0, 33, 1, 1'b0);
        wr(18'h0, 16'h00E8);
        wr(18'h0, 16'h0003);
        wr(18'h0, 16'h00FF);
        rd(18'h0, d);
        chk(d, model[0], "R9 later write decoded as read-array command");
        wr(18'h0, 16'h0070);
        rd(18'h0, d);
        chk(d, 16'h00B0, "R9 errors kept after refused setup");
        wr(18'h0, 16'h0050);
        rd(18'h0, d);
        chk(d, 16'h0080, "R9 clear");

        // R8 protected block
        prot = 4'b0100;
        run_seq(2'd2, 7, 0, 1'b0);
        rd(18'h0, d);
        chk(d, 16'h0092, "R8 protection error no busy");
        readback("R8 array unchanged");
        prot = 4'b0000;

        // R10 writes during busy with bits 4 and 1 still set
        wr(18'h0, 16'h0070);
        run_seq(2'd0, 3, 0, 1'b1);
        wr(18'h0, 16'h0050);
        wr(18'h0, 16'h00FF);
        wr(18'h0, 16'h00E8);
        rd(18'h3_0007, d);
        chk(d, model[aidx(18'h3_0007)], "R10 read-array accepted, setup ignored while busy");
        wr(18'h0, 16'h0070);
        wait_ready(c);
        rd(18'h0, d);
        chk(d, 16'h0092, "R10 clear ignored while busy");
        wr(18'h0, 16'h0050);
        rd(18'h0, d);
        chk(d, 16'h0080, "R9 clear after busy");
        readback("R10 program completed");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int kind;
            kind = ($urandom % 4 == 0) ? 1 + int'($urandom % 6) : 0;
            do_case(2'($urandom % 4), int'($urandom % 32), kind);
        end
        readback("R6 random programs");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule